// File: doc/BRIEF.md
# PHY Management Command Unit

This block carries out single read and write transactions on a two-wire PHY management bus. Software fills in a PHY address, a register number and, for a write, a 16-bit data word. It then sets a read or a write bit in the control register. The unit generates the management clock and shifts out the complete serial frame: a 32-bit preamble of ones, the start and opcode fields, both addresses, the turnaround and 16 data bits. When the frame ends, the unit clears the command bit. For a read, it also writes the 16 bits it captured into the data register.

The command bit doubles as the busy flag, so software only needs to poll it. The PHY-address register has a rate-select bit that shortens the management clock half period. The control register also has a manual mode, in which software drives the clock, the data-out level and the output enable directly and reads the line back.

Top module: `mdio_cmd_unit`

## Requirements
- R1: After reset, every register reads zero apart from the line sample in control bit 1, and `mdc`, `mdioOut` and `mdioOe` are low.
- R2: The register select `regAddr` decodes as follows:
  - 0 is the PHY-address register: address in bits 4:0, fast-rate select in bit 5.
  - 1 is the register-number register: bits 4:0.
  - 2 is the 16-bit data register.
  - 3 is the control register.
  - Bits a register does not implement read as zero.
- R3: Setting control bit 5 (write) produces exactly 64 clock cycles. The line carries, in order:
  - 32 ones, then 0,1, then 0,1;
  - the PHY address, MSB first, then the register number, MSB first;
  - 1,0, then the data register, MSB first.
  - The output enable is high for all 64 bits.
- R4: Setting control bit 6 (read) sends opcode 1,0 and drives the first 46 bits. It releases the line (output enable low) for the last 18 bits. It samples the 16 values seen on the rising clock edges of the last 16 bits, MSB first, into the data register.
- R5: A command bit reads as one for the whole transaction. It clears on the same clock edge as the 64th falling management clock edge, after which `mdc` and `mdioOe` are low.
- R6: While a transaction runs, `mdioOut` and `mdioOe` change only together with a falling `mdc`, never on its rising edge.
- R7: The management clock half period is HALF_SLOW system clocks, or HALF_FAST clocks when bit 5 of the PHY-address register is set at command start.
- R8: Any write to the control register while a transaction runs is ignored, including command bits and manual-mode bits.
- R9: A control write with both command bits set runs a read.
- R10: With control bit 4 set:
  - `mdc` follows bit 0, `mdioOut` follows bit 2 and `mdioOe` follows bit 3.
  - Control bit 1 always reads the current `mdioIn` level.
- R11: A control write that has bit 4 set starts no transaction. Writing zero to the control register leaves the unit idle with all three bus outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for reads and writes |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for the data line |
| mdioIn | input | 1 | Serial data line level as seen by the unit |

## Verification
The bench sweeps both opcodes and both clock rates over several address and data patterns. It compares every captured bit and enable against a frame it assembles itself, so an off-by-one in a field width or a turnaround driven on a read shows up as a bit mismatch. It measures every clock period, so a divider stuck on one rate, or one that counts a cycle too many, fails the rate check. A second command and a manual-mode write during a read must leave the read intact; a design that honoured them would produce extra clock edges or a corrupted data register. It also checks that both command bits together give a read, and that a command with manual mode set starts nothing.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int READ_DRIVE_LEN = FRAME_LEN - DATA_W - 2;
  localparam int SEL_W     = 2;

  // control register bit positions
  localparam int CB_CLK  = 0;
  localparam int CB_DIN  = 1;
  localparam int CB_DOUT = 2;
  localparam int CB_OE   = 3;
  localparam int CB_MAN  = 4;
  localparam int CB_WR   = 5;
  localparam int CB_RD   = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_PHY  = 2'd0,
    SEL_REG  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } regSel_e;

  typedef struct packed {
    logic load;    // capture frame, start sequence
    logic sample;  // rising mdc: shift in line level
    logic shift;   // falling mdc: advance to next bit
    logic done;    // final falling mdc: finish
  } seqStrobe_t;

endpackage

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              mdioIn,
  input  seqStrobe_t        strobe,
  output logic              cmdRd,
  output logic              cmdWr,
  output logic              fastSel,
  output logic              frameBit,
  output logic              manualEn,
  output logic              manClk,
  output logic              manDout,
  output logic              manOe
);

  logic [ADDR_W-1:0]    phyAddr;
  logic [ADDR_W-1:0]    regNum;
  logic [DATA_W-1:0]    dataReg;
  logic [DATA_W-1:0]    rxShift;
  logic [FRAME_LEN-1:0] frameSh;
  logic [FRAME_LEN-1:0] frameLoad;
  logic                 busy;
  logic                 ctrlWr;
  logic                 startOk;
  logic [1:0]           opBits;
  logic [1:0]           taBits;
  logic [DATA_W-1:0]    payload;

  assign busy    = cmdRd | cmdWr;
  assign ctrlWr  = regWrEn && (regAddr == SEL_CTRL) && !busy;
  assign startOk = ctrlWr && !regWrData[CB_MAN] &&
                   (regWrData[CB_RD] || regWrData[CB_WR]);

  always_comb begin
    opBits    = cmdRd ? 2'b10 : 2'b01;
    taBits    = cmdRd ? 2'b11 : 2'b10;
    payload   = cmdRd ? {DATA_W{1'b1}} : dataReg;
    frameLoad = {{PRE_LEN{1'b1}}, 2'b01, opBits, phyAddr, regNum, taBits, payload};
  end

  assign frameBit = frameSh[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyAddr  <= '0;
      fastSel  <= 1'b0;
      regNum   <= '0;
      dataReg  <= '0;
      rxShift  <= '0;
      frameSh  <= '0;
      cmdRd    <= 1'b0;
      cmdWr    <= 1'b0;
      manualEn <= 1'b0;
      manClk   <= 1'b0;
      manDout  <= 1'b0;
      manOe    <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == SEL_PHY))
        {fastSel, phyAddr} <= regWrData[ADDR_W:0];
      if (regWrEn && (regAddr == SEL_REG))
        regNum <= regWrData[ADDR_W-1:0];

      if (strobe.done && cmdRd)
        dataReg <= rxShift;
      else if (regWrEn && (regAddr == SEL_DATA))
        dataReg <= regWrData;

      if (ctrlWr) begin
        manualEn <= regWrData[CB_MAN];
        manClk   <= regWrData[CB_CLK];
        manDout  <= regWrData[CB_DOUT];
        manOe    <= regWrData[CB_OE];
        cmdRd    <= startOk && regWrData[CB_RD];
        cmdWr    <= startOk && !regWrData[CB_RD] && regWrData[CB_WR];
      end else if (strobe.done) begin
        cmdRd <= 1'b0;
        cmdWr <= 1'b0;
      end

      if (strobe.sample)
        rxShift <= {rxShift[DATA_W-2:0], mdioIn};

      if (strobe.load)
        frameSh <= frameLoad;
      else if (strobe.shift)
        frameSh <= {frameSh[FRAME_LEN-2:0], 1'b1};
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      SEL_PHY:  regRdData[ADDR_W:0]   = {fastSel, phyAddr};
      SEL_REG:  regRdData[ADDR_W-1:0] = regNum;
      SEL_DATA: regRdData             = dataReg;
      default: begin
        regRdData[CB_CLK]  = manClk;
        regRdData[CB_DIN]  = mdioIn;
        regRdData[CB_DOUT] = manDout;
        regRdData[CB_OE]   = manOe;
        regRdData[CB_MAN]  = manualEn;
        regRdData[CB_WR]   = cmdWr;
        regRdData[CB_RD]   = cmdRd;
      end
    endcase
  end

endmodule

// File: rtl/mdio_cmd_seq.sv
module mdio_cmd_seq
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_SLOW = 4,
  parameter int HALF_FAST = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       isRead,
  input  logic       fastSel,
  output seqStrobe_t strobe,
  output logic       mdcSeq,
  output logic       oeSeq
);

  localparam int CNT_W = $clog2(HALF_SLOW + 1);

  logic             running;
  logic             fastLat;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] halfLim;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             halfHit;
  logic             lastBit;

  function automatic logic driveAt(input logic [IDX_W-1:0] idx, input logic rd);
    return !rd || (idx < IDX_W'(READ_DRIVE_LEN));
  endfunction

  assign halfLim = fastLat ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_SLOW - 1);
  assign halfHit = running && (halfCnt == halfLim);
  assign lastBit = (bitIdx == IDX_W'(FRAME_LEN - 1));
  assign nextIdx = bitIdx + 1'b1;

  always_comb begin
    strobe.load   = !running && busy;
    strobe.sample = halfHit && !mdcSeq;
    strobe.shift  = halfHit && mdcSeq && !lastBit;
    strobe.done   = halfHit && mdcSeq && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      fastLat <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
      mdcSeq  <= 1'b0;
      oeSeq   <= 1'b0;
    end else if (strobe.load) begin
      running <= 1'b1;
      fastLat <= fastSel;
      halfCnt <= '0;
      bitIdx  <= '0;
      mdcSeq  <= 1'b0;
      oeSeq   <= 1'b1;
    end else if (running) begin
      if (halfHit) begin
        halfCnt <= '0;
        if (!mdcSeq) begin
          mdcSeq <= 1'b1;
        end else begin
          mdcSeq <= 1'b0;
          if (lastBit) begin
            running <= 1'b0;
            oeSeq   <= 1'b0;
          end else begin
            bitIdx <= nextIdx;
            oeSeq  <= driveAt(nextIdx, isRead);
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio_cmd_unit.sv
module mdio_cmd_unit
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_SLOW = 4,
  parameter int HALF_FAST = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  seqStrobe_t strobe;
  logic cmdRd, cmdWr, busy, fastSel, frameBit;
  logic manualEn, manClk, manDout, manOe;
  logic mdcSeq, oeSeq;

  assign busy = cmdRd | cmdWr;

  mdio_cmd_regs uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdioIn(mdioIn),
    .strobe(strobe), .cmdRd(cmdRd), .cmdWr(cmdWr), .fastSel(fastSel),
    .frameBit(frameBit), .manualEn(manualEn), .manClk(manClk),
    .manDout(manDout), .manOe(manOe)
  );

  mdio_cmd_seq #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) uSeq (
    .clk(clk), .rstN(rstN), .busy(busy), .isRead(cmdRd), .fastSel(fastSel),
    .strobe(strobe), .mdcSeq(mdcSeq), .oeSeq(oeSeq)
  );

  assign mdc     = manualEn ? manClk  : mdcSeq;
  assign mdioOe  = manualEn ? manOe   : oeSeq;
  assign mdioOut = manualEn ? manDout : (oeSeq & frameBit);

endmodule

// File: rtl/mdio_cmd_unit_chk.sv
module mdio_cmd_unit_chk (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic busy,
  input logic manualEn,
  input logic cmdRd,
  input logic cmdWr
);

  AST_EDGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $rose(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !manualEn) |-> (!mdc && !mdioOe)); // R11

  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdRd, cmdWr})); // R9

  AST_MANUAL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && manualEn)); // R8

  AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(mdc)); // R5

endmodule

bind mdio_cmd_unit mdio_cmd_unit_chk uChk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busy), .manualEn(manualEn), .cmdRd(cmdRd), .cmdWr(cmdWr)
);

// File: tb/mdio_cmd_unit_test.sv
module mdio_cmd_unit_test;

  localparam int HS = 4;
  localparam int HF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn;

  int errCnt = 0;
  int chkCnt = 0;
  int riseCnt = 0;
  int cycle = 0;
  int lastRise = 0;
  int minP = 0;
  int maxP = 0;
  logic prevMdc = 1'b0;
  logic capOut [0:127];
  logic capOe  [0:127];
  logic [15:0] readVal = 16'd0;
  logic phyOverride = 1'b0;
  logic phyLevel = 1'b1;

  always #2 clk = ~clk;

  mdio_cmd_unit #(.HALF_SLOW(HS), .HALF_FAST(HF)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: returns readVal MSB first during the last 16 bits, pulled up otherwise
  always @* begin
    if (phyOverride)
      mdioIn = phyLevel;
    else if (riseCnt >= 48 && riseCnt < 64)
      mdioIn = readVal[63 - riseCnt];
    else
      mdioIn = 1'b1;
  end

  always @(negedge clk) begin
    cycle <= cycle + 1;
    if (mdc && !prevMdc) begin
      if (riseCnt < 128) begin
        capOut[riseCnt] = mdioOut;
        capOe[riseCnt]  = mdioOe;
      end
      if (riseCnt > 0) begin
        if (minP == 0 || cycle - lastRise < minP) minP = cycle - lastRise;
        if (cycle - lastRise > maxP) maxP = cycle - lastRise;
      end
      lastRise = cycle;
      riseCnt  = riseCnt + 1;
    end
    prevMdc = mdc;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic expBit(input int i, input bit rd, input logic [4:0] p,
                                  input logic [4:0] r, input logic [15:0] d);
    if (i < 32)  return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return rd;
    if (i == 35) return !rd;
    if (i < 41)  return p[40 - i];
    if (i < 46)  return r[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return d[63 - i];
  endfunction

  task automatic runTxn(input logic [15:0] ctrlVal, input bit rd, input logic [4:0] p,
                        input logic [4:0] r, input logic [15:0] d, input bit fast,
                        input bit intrude);
    logic [15:0] v;
    int bad, badOe, waitN;
    string fr;
    fr = rd ? "R4" : "R3";
    readVal = d;
    wrReg(2'd0, {10'd0, fast, p});
    wrReg(2'd1, {11'd0, r});
    wrReg(2'd2, rd ? ~d : d);
    riseCnt = 0; minP = 0; maxP = 0;
    wrReg(2'd3, ctrlVal);
    repeat (20) @(negedge clk);
    rdReg(2'd3, v);
    check(v[6:5] == (rd ? 2'b10 : 2'b01), "R5 command bit held while busy (R9 when both set)",
          64'(v[6:5]), rd ? 64'd2 : 64'd1);
    if (intrude) begin
      wrReg(2'd3, 16'h0020);
      wrReg(2'd3, 16'h001D);
    end
    waitN = 0;
    do begin
      rdReg(2'd3, v);
      waitN++;
    end while (v[6:5] != 2'b00 && waitN < 3000);
    check(!mdc && !mdioOe, "R5 bus idle at completion", {mdc, mdioOe}, 0);
    check(riseCnt == 64, {fr, " clock count"}, 64'(riseCnt), 64);
    check(minP == 2 * (fast ? HF : HS) && maxP == minP, "R7 mdc period",
          64'(maxP), 64'(2 * (fast ? HF : HS)));
    bad = 0; badOe = 0;
    for (int i = 0; i < 64; i++) begin
      bit drv;
      drv = !rd || i < 46;
      if (capOe[i] !== drv) badOe++;
      if (drv && capOut[i] !== expBit(i, rd, p, r, d)) bad++;
    end
    check(bad == 0, {fr, " frame bits"}, 64'(bad), 0);
    check(badOe == 0, {fr, " output enable pattern"}, 64'(badOe), 0);
    rdReg(2'd2, v);
    check(v == d, rd ? "R4 read data latched" : "R3 data register kept", 64'(v), 64'(d));
    if (intrude) begin
      rdReg(2'd3, v);
      check((v & 16'hFFFD) == 16'h0000, "R8 control writes while busy ignored",
            64'(v), 0);
    end
    riseCnt = 0;
  endtask

  initial begin
    logic [15:0] v;
    logic [4:0] pList [0:2];
    logic [4:0] rList [0:2];
    logic [15:0] dList [0:2];
    pList[0] = 5'd0;  pList[1] = 5'h15; pList[2] = 5'h1F;
    rList[0] = 5'h1F; rList[1] = 5'h0A; rList[2] = 5'h00;
    dList[0] = 16'hA5C3; dList[1] = 16'h0001; dList[2] = 16'h8000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(2'd0, v); check(v == 0, "R1 phy reg reset", 64'(v), 0);
    rdReg(2'd1, v); check(v == 0, "R1 reg-number reset", 64'(v), 0);
    rdReg(2'd2, v); check(v == 0, "R1 data reset", 64'(v), 0);
    rdReg(2'd3, v); check((v & 16'hFFFD) == 0, "R1 control reset", 64'(v), 0);
    check(!mdc && !mdioOut && !mdioOe, "R1 bus outputs low", {mdc, mdioOut, mdioOe}, 0);

    // R2 field widths
    wrReg(2'd0, 16'hFFFF); rdReg(2'd0, v); check(v == 16'h003F, "R2 phy reg width", 64'(v), 64'h3F);
    wrReg(2'd1, 16'hFFFF); rdReg(2'd1, v); check(v == 16'h001F, "R2 reg-number width", 64'(v), 64'h1F);
    wrReg(2'd2, 16'h1234); rdReg(2'd2, v); check(v == 16'h1234, "R2 data width", 64'(v), 64'h1234);

    // sweep over opcode, rate and field patterns (R3 R4 R5 R7)
    for (int rdI = 0; rdI < 2; rdI++)
      for (int fI = 0; fI < 2; fI++)
        for (int c = 0; c < 3; c++)
          runTxn(rdI != 0 ? 16'h0040 : 16'h0020, rdI != 0, pList[c], rList[c],
                 dList[c] ^ 16'(fI * 16'h0F0F), fI != 0, 1'b0);

    // R9 both command bits: read wins
    runTxn(16'h0060, 1'b1, 5'h0C, 5'h13, 16'h6DB6, 1'b1, 1'b0);
    // R8 writes during a read are ignored
    runTxn(16'h0040, 1'b1, 5'h03, 5'h11, 16'hC001, 1'b0, 1'b1);

    // R10 manual mode
    wrReg(2'd3, 16'h001D);
    check(mdc && mdioOut && mdioOe, "R10 manual drive high", {mdc, mdioOut, mdioOe}, 7);
    wrReg(2'd3, 16'h0018);
    check(!mdc && !mdioOut && mdioOe, "R10 manual clock/data low", {mdc, mdioOut, mdioOe}, 1);
    phyOverride = 1'b1; phyLevel = 1'b0;
    rdReg(2'd3, v); check(v[1] == 1'b0, "R10 line sample low", 64'(v[1]), 0);
    phyLevel = 1'b1;
    rdReg(2'd3, v); check(v[1] == 1'b1, "R10 line sample high", 64'(v[1]), 1);
    phyOverride = 1'b0;

    // R11 command with manual bit set starts nothing; zero write idles
    wrReg(2'd3, 16'h0000);
    riseCnt = 0;
    wrReg(2'd3, 16'h0030);
    repeat (100) @(negedge clk);
    check(riseCnt == 0, "R11 command in manual mode ignored", 64'(riseCnt), 0);
    rdReg(2'd3, v); check((v & 16'hFFFD) == 16'h0010, "R11 control holds manual only", 64'(v), 64'h10);
    wrReg(2'd3, 16'h0000);
    check(!mdc && !mdioOut && !mdioOe, "R11 zero write drops drive", {mdc, mdioOut, mdioOe}, 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule